// File: doc/BRIEF.md
# Multiplexed Converter Serial Port

This block is the digital serial side of a multi-channel 12-bit sampling converter. A host clocks it with SCLK and frames transfers with an active-low chip select. Each frame runs for sixteen SCLK clocks. During the first four clocks the host shifts configuration bits in on DIN, which choose the input channel for the following frame. During the last twelve clocks the block shifts out the previous conversion result, most significant bit first. The analog core is replaced by a parallel sample bus. The block asks for that sample once per frame and reports which channel the core should convert.

DOUT comes out as a data bit plus an output enable. The enable is low everywhere except the twelve data clocks, so DIN and DOUT can share one wire. A STATUS flag marks the active part of each frame. The host can run the port in two ways. In slave mode it raises chip select between conversions, and each falling edge of chip select opens a new frame. In free-running mode chip select stays low, and frames follow one another with a single dead clock between them. Raising chip select in the middle of a frame abandons that frame.

Top module: `adc_serial_port`

## Requirements
- R1: STATUS goes high at the first SCLK rising edge of a frame and stays high through the 16th rising edge. It is low while idle and during the dead clock.
- R2: The DOUT enable is low during the first four clocks of a frame, while idle, during the dead clock and whenever chip select is high.
- R3: After the falling edges that follow rising edges 4 to 15, DOUT carries result bits 11 down to 0, MSB first, with the enable high. After the falling edge that follows rising edge 16, the enable is low again.
- R4: DIN is sampled on rising edges 1 to 4 of a frame. The first bit is an enable, the second and third bits are the channel number (MSB first), and the fourth bit has no effect.
- R5: When the enable bit is 1, the channel taken in frame n appears on the channel output at the 16th rising edge of frame n, so it applies to frame n+1. When the enable bit is 0, the channel output keeps its value.
- R6: The sample request is high after rising edges 1 to 3. The sample bus is captured at rising edge 4. If the valid input is low at that edge, the result shifted out is zero.
- R7: In slave mode, a frame starts at the first SCLK rising edge after chip select falls. Raising chip select after a complete frame returns the port to idle.
- R8: With chip select held low, exactly one dead SCLK clock follows the 16th clock. During that clock STATUS and the DOUT enable are low, and the next rising edge starts a new frame.
- R9: Raising chip select before the 16th rising edge aborts the frame. The DOUT enable and STATUS drop at once, and any partly received channel setting is discarded.
- R10: While rst_n is low, the channel output is 0, and STATUS, the DOUT enable and the sample request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; holding it low gives free-running mode |
| din | input | 1 | Configuration data, sampled on SCLK rising edges |
| samp_data | input | 12 | Conversion result from the analog core |
| samp_valid | input | 1 | samp_data holds a valid result |
| samp_req | output | 1 | Asks the core for the sample of the current frame |
| samp_ch | output | 2 | Channel the core converts in the current frame |
| dout | output | 1 | Serial result bit, updated on SCLK falling edges |
| dout_oe | output | 1 | Output enable for dout (low = high impedance) |
| status | output | 1 | High during the active part of a frame |

## Verification
Some properties are checked on every rising edge. The DOUT enable may be high only inside the twelve data clocks and only while STATUS is high. When STATUS falls with chip select low, it must rise again one clock later. The channel output may change only at the commit edge. The bench scenarios cover the rest: the exact bit order of results such as single-MSB and single-LSB words, the one-frame delay of the channel setting, the effect of an invalid sample, the fourth configuration bit being ignored, and the discarding of configuration when a frame is aborted. These depend on the stimulus and cannot be read from one cycle.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  // Slot numbering: 0 = idle, 1..frame_len = frame clocks, frame_len+1 = dead clock
  function automatic int next_slot(int slot, int frame_len);
    if (slot == 0 || slot == frame_len + 1) return 1;
    return slot + 1;
  endfunction

  // Index of the result bit driven after the falling edge in a given slot
  function automatic int tx_bit(int slot, int frame_len);
    return frame_len - 1 - slot;
  endfunction

  // True when the slot drives a result bit after its falling edge
  function automatic bit in_data(int slot, int lead, int frame_len);
    return (slot >= lead) && (slot < frame_len);
  endfunction

endpackage

// File: rtl/adcsp_frame_seq.sv
module adcsp_frame_seq #(
  parameter int LEAD   = 4,
  parameter int DATA_W = 12,
  localparam int FRAME = LEAD + DATA_W,
  localparam int POS_W = $clog2(FRAME + 2)
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  output logic [POS_W-1:0] pos,
  output logic             status,
  output logic             samp_req,
  output logic             shift_evt,
  output logic             load_evt,
  output logic             commit_evt
);
  import adcsp_pkg::*;

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)     pos_q <= '0;
    else if (cs_n)  pos_q <= '0;
    else            pos_q <= POS_W'(next_slot(int'(pos_q), FRAME));
  end

  assign pos        = pos_q;
  assign status     = (pos_q != '0) && (int'(pos_q) <= FRAME);
  assign samp_req   = (pos_q != '0) && (int'(pos_q) < LEAD);
  // events name the rising edge that is about to happen
  assign shift_evt  = (int'(pos_q) < LEAD) || (int'(pos_q) == FRAME + 1);
  assign load_evt   = (int'(pos_q) == LEAD - 1);
  assign commit_evt = (int'(pos_q) == FRAME - 1);

  // R8
  one_dead_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    $fell(status) |=> status);

endmodule

// File: rtl/adcsp_cfg_rx.sv
module adcsp_cfg_rx #(
  parameter int LEAD = 4,
  parameter int CH_W = 2
) (
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            din,
  input  logic            shift_evt,
  input  logic            commit_evt,
  output logic [CH_W-1:0] ch
);
  // Layout after LEAD shifts: [LEAD-1] enable, next CH_W bits channel, rest unused.
  localparam int EN_BIT = LEAD - 1;
  localparam int CH_HI  = LEAD - 2;

  logic [LEAD-1:0] cfg_q;
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (cs_n)      cfg_q <= '0;
    else if (shift_evt) cfg_q <= {cfg_q[LEAD-2:0], din};
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)                        ch_q <= '0;
    else if (commit_evt && cfg_q[EN_BIT]) ch_q <= cfg_q[CH_HI -: CH_W];
  end

  assign ch = ch_q;

  // R5
  ch_commit_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (ch_q != $past(ch_q)) |-> $past(commit_evt));

endmodule

// File: rtl/adcsp_dout_tx.sv
module adcsp_dout_tx #(
  parameter int LEAD   = 4,
  parameter int DATA_W = 12,
  localparam int FRAME = LEAD + DATA_W,
  localparam int POS_W = $clog2(FRAME + 2)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [POS_W-1:0]  pos,
  input  logic              load_evt,
  input  logic [DATA_W-1:0] samp_data,
  input  logic              samp_valid,
  output logic              dout,
  output logic              dout_oe
);
  import adcsp_pkg::*;

  logic [DATA_W-1:0] word_q;
  logic              dout_q, oe_q;
  logic              drive_now;
  logic [$clog2(DATA_W)-1:0] bit_sel;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (load_evt) word_q <= samp_valid ? samp_data : '0;
  end

  assign drive_now = in_data(int'(pos), LEAD, FRAME);
  assign bit_sel   = drive_now ? $bits(bit_sel)'(tx_bit(int'(pos), FRAME)) : '0;

  always_ff @(negedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n || cs_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      oe_q   <= drive_now;
      dout_q <= drive_now ? word_q[bit_sel] : 1'b0;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

  // R3
  oe_window_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    oe_q |-> ((int'(pos) >= LEAD) && (int'(pos) < FRAME)));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int LEAD   = 4,
  parameter int DATA_W = 12,
  parameter int CH_W   = 2,
  localparam int FRAME = LEAD + DATA_W,
  localparam int POS_W = $clog2(FRAME + 2)
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic [DATA_W-1:0] samp_data,
  input  logic              samp_valid,
  output logic              samp_req,
  output logic [CH_W-1:0]   samp_ch,
  output logic              dout,
  output logic              dout_oe,
  output logic              status
);
  logic [POS_W-1:0] pos;
  logic shift_evt, load_evt, commit_evt;

  adcsp_frame_seq #(.LEAD(LEAD), .DATA_W(DATA_W)) u_seq (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .pos(pos), .status(status),
    .samp_req(samp_req), .shift_evt(shift_evt), .load_evt(load_evt),
    .commit_evt(commit_evt)
  );

  adcsp_cfg_rx #(.LEAD(LEAD), .CH_W(CH_W)) u_cfg (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
    .shift_evt(shift_evt), .commit_evt(commit_evt), .ch(samp_ch)
  );

  adcsp_dout_tx #(.LEAD(LEAD), .DATA_W(DATA_W)) u_tx (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .pos(pos), .load_evt(load_evt),
    .samp_data(samp_data), .samp_valid(samp_valid), .dout(dout), .dout_oe(dout_oe)
  );

  // R2
  oe_status_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    dout_oe |-> status);

endmodule

// File: tb/tb_adc_serial_port.sv
`timescale 1ns/1ps
module tb_adc_serial_port;
  localparam int SCLK_PERIOD = 20;
  localparam int HALF = SCLK_PERIOD / 2;
  localparam int QTR  = SCLK_PERIOD / 4;

  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [11:0] samp_data = '0;
  logic samp_valid = 1'b0;
  logic samp_req, dout, dout_oe, status;
  logic [1:0] samp_ch;

  int n_vec = 0, n_bad = 0;
  logic [1:0] exp_ch = 2'd0;
  bit done = 0;

  adc_serial_port dut (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .samp_data(samp_data),
    .samp_valid(samp_valid), .samp_req(samp_req), .samp_ch(samp_ch),
    .dout(dout), .dout_oe(dout_oe), .status(status)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one SCLK period starting and ending in the low phase
  task automatic pulse();
    #QTR; sclk = 1'b1; #HALF; sclk = 1'b0; #QTR;
  endtask

  // runs one frame; abort_at > 0 raises cs_n after that clock
  task automatic run_frame(input logic [3:0] cfg, input logic [11:0] data,
                           input logic valid, input int abort_at);
    logic [11:0] word;
    logic [1:0]  nxt;
    word = valid ? data : 12'h000;
    nxt  = cfg[3] ? cfg[2:1] : exp_ch;
    samp_data = data; samp_valid = valid;
    for (int k = 1; k <= 16; k++) begin
      din = (k <= 4) ? cfg[4-k] : 1'b0;
      pulse();
      chk("R1", "status in frame", int'(status), 1);
      chk("R6", "samp_req", int'(samp_req), (k <= 3) ? 1 : 0);
      if (k >= 4 && k <= 15) begin
        chk("R3", "dout_oe data clock", int'(dout_oe), 1);
        chk("R3", $sformatf("dout bit %0d", 15 - k), int'(dout), int'(word[15-k]));
      end else begin
        chk("R2", "dout_oe lead/end", int'(dout_oe), 0);
      end
      chk("R5", "samp_ch", int'(samp_ch), (k < 16) ? int'(exp_ch) : int'(nxt));
      if (k == abort_at) begin
        cs_n = 1'b1; #1;
        chk("R9", "abort oe", int'(dout_oe), 0);
        chk("R9", "abort status", int'(status), 0);
        #(QTR - 1);
        return;
      end
    end
    exp_ch = nxt;
  endtask

  task automatic dead_clock();
    din = 1'b1;
    pulse();
    chk("R8", "dead status", int'(status), 0);
    chk("R8", "dead oe", int'(dout_oe), 0);
    chk("R8", "dead samp_req", int'(samp_req), 0);
  endtask

  task automatic t_reset();
    #(SCLK_PERIOD);
    chk("R10", "reset status", int'(status), 0);
    chk("R10", "reset oe", int'(dout_oe), 0);
    chk("R10", "reset ch", int'(samp_ch), 0);
    chk("R10", "reset req", int'(samp_req), 0);
    rst_n = 1'b1; #(SCLK_PERIOD);
  endtask

  task automatic slave_frame(input logic [3:0] cfg, input logic [11:0] data, input logic valid);
    cs_n = 1'b0; #QTR;
    chk("R7", "pre-clock status", int'(status), 0);
    chk("R7", "pre-clock oe", int'(dout_oe), 0);
    run_frame(cfg, data, valid, 0);
    cs_n = 1'b1; #QTR;
    chk("R7", "idle status", int'(status), 0);
    chk("R7", "idle oe", int'(dout_oe), 0);
    chk("R5", "ch held idle", int'(samp_ch), int'(exp_ch));
  endtask

  task automatic t_abort();
    cs_n = 1'b0; #QTR;
    run_frame(4'b1010, 12'h555, 1'b1, 8);
    pulse();
    chk("R9", "idle after abort", int'(status), 0);
    chk("R9", "ch discarded", int'(samp_ch), int'(exp_ch));
    slave_frame(4'b0000, 12'hC3A, 1'b1);
  endtask

  task automatic t_free_run();
    cs_n = 1'b0; #QTR;
    run_frame(4'b1110, 12'h800, 1'b1, 0);
    dead_clock();
    run_frame(4'b0111, 12'h001, 1'b1, 0);
    dead_clock();
    run_frame(4'b1001, 12'hFFF, 1'b1, 0);
    cs_n = 1'b1; #QTR;
  endtask

  initial begin
    t_reset();
    slave_frame(4'b1100, 12'hA5C, 1'b1);   // R4: enable, ch 2
    slave_frame(4'b0011, 12'h3F0, 1'b1);   // R4: enable 0, last bit ignored
    slave_frame(4'b1011, 12'h7E1, 1'b0);   // R6: invalid sample, R4 ch 1
    t_abort();
    t_free_run();
    slave_frame(4'b1001, 12'h5A5, 1'b1);   // R4: fourth bit ignored, ch 0
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(SCLK_PERIOD * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule